// File: doc/BRIEF.md
# APB Transfer Rule Watcher

This block sits beside an APB slave port and only listens. Every rising clock edge it samples the select, enable, ready, error, address, direction and write-data lines, together with the bus-side reset. It keeps its own copy of where the current transfer stands: idle, in its first cycle, or in the access phase waiting for the slave. When the bus breaks the ordering or stability rules of a transfer, the block records the problem. It never drives anything back onto the bus.

Each kind of rule breach sets its own sticky flag bit. A small code output holds the number of the first breach seen since the last clear. Two saturating counters give a test environment a running total of completed transfers and of wait-state cycles. The flags and the code are cleared by a one-cycle clear pulse. The monitor's own reset clears everything. The bus reset is a separate input that the monitor samples as ordinary bus data.

Top module: `apb_rule_watch`

## Requirements
- R1: Enable high in a cycle where select is low, or enable high with select high when the tracked phase is idle (the previous cycle was neither a setup cycle nor an access cycle with ready low), is an enable-without-setup breach: code 1, flag bit 0.
- R2: Two back-to-back cycles with select high and enable low are a setup-length breach: code 2, flag bit 1.
- R3: While the bus reset is high, the error line high in any cycle where select, enable and ready are not all high is an error-window breach: code 3, flag bit 2. Error high together with all three is legal.
- R4: In every access cycle that follows a setup, the address and direction must equal the values sampled in that setup cycle. Otherwise it is a control-stability breach: code 4, flag bit 3.
- R5: In access cycles of a write (direction high at setup), the write data must equal the value sampled at setup. Otherwise it is a data-stability breach: code 5, flag bit 4. Write-data changes during reads have no effect.
- R6: With the bus reset low, select or enable high is a reset-select breach: code 6, flag bit 5. The tracked phase returns to idle, so an enable in the next cycle is an R1 breach.
- R7: Flag bits are sticky. Each cycle ORs in new breaches, and no bit falls except on clear or on monitor reset.
- R8: The code holds the first breach after a clear. When several breaches occur in one cycle, the lowest code number wins. A clear in the same cycle as a breach leaves both flags and code at zero.
- R9: The transfer counter adds one for each legal access cycle with ready high. The wait counter adds one for each legal access cycle with ready low. Both stop at 2^CNT_W-1.
- R10: While the monitor reset is low, flags, code and both counters read zero.
- R11: A bus cycle sampled at a rising edge is reflected in every output right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples everything |
| rst_n | input | 1 | Monitor reset, asynchronous assert, active low |
| bus_rst_n | input | 1 | Observed bus reset, active low, sampled synchronously |
| bus_sel | input | 1 | Observed slave select |
| bus_en | input | 1 | Observed enable (access phase marker) |
| bus_rdy | input | 1 | Observed slave ready |
| bus_err | input | 1 | Observed slave error response |
| bus_addr | input | AW | Observed address |
| bus_wr | input | 1 | Observed direction, 1 = write |
| bus_wdata | input | DW | Observed write data |
| viol_clr | input | 1 | Clears flags and code at the next edge |
| viol_flags | output | 6 | Sticky breach flags, bit n-1 for code n |
| viol_code | output | 3 | First breach code since clear, 0 = none |
| xfer_cnt | output | CNT_W | Saturating count of completed transfers |
| wait_cnt | output | CNT_W | Saturating count of wait-state cycles |

## Verification
Legal transfers with random wait lengths, directions and data are the baseline. Because the flags stay zero while the counters move, they separate a correct phase tracker from one that misreads wait cycles. Each breach is then injected on its own: a doubled setup, an error outside completion, an address or data change in the access phase, a stray enable, and a select during bus reset. Each must light exactly one flag and code. Paired breaches in one cycle, a clear that coincides with a breach, and write-data changes during reads tell the priority rule and the read/write split apart from near-miss designs. Long bursts drive both counters into saturation.

// File: rtl/apb_rule_pkg.sv
package apb_rule_pkg;
  localparam int NUM_VIOL = 6;
  localparam int CODE_W   = 3;

  // flag bit positions; code value is position + 1
  localparam int V_ENA   = 0;
  localparam int V_SETUP = 1;
  localparam int V_ERR   = 2;
  localparam int V_CTRL  = 3;
  localparam int V_DATA  = 4;
  localparam int V_RST   = 5;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_WAIT  = 2'd2
  } ph_t;
endpackage

// File: rtl/apb_phase_track.sv
module apb_phase_track
  import apb_rule_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rst_n,
  input  logic                sel,
  input  logic                en,
  input  logic                rdy,
  input  logic                err,
  input  logic [AW-1:0]       addr,
  input  logic                wr,
  input  logic [DW-1:0]       wdata,
  output logic [NUM_VIOL-1:0] det,
  output logic                done,
  output logic                waitc
);
  ph_t           ph_q, ph_d;
  logic          cap_ld;
  logic [AW-1:0] cap_addr_q;
  logic          cap_wr_q;
  logic [DW-1:0] cap_wdata_q;

  always_comb begin
    ph_d   = ph_q;
    cap_ld = 1'b0;
    det    = '0;
    done   = 1'b0;
    waitc  = 1'b0;
    if (!bus_rst_n) begin
      ph_d       = PH_IDLE;
      det[V_RST] = sel | en;
    end else begin
      det[V_ERR] = err & ~(sel & en & rdy);
      if (!sel) begin
        ph_d       = PH_IDLE;
        det[V_ENA] = en;
      end else if (!en) begin
        det[V_SETUP] = (ph_q == PH_SETUP);
        ph_d         = PH_SETUP;
        cap_ld       = 1'b1;
      end else if (ph_q == PH_IDLE) begin
        det[V_ENA] = 1'b1;
        ph_d       = PH_IDLE;
      end else begin
        det[V_CTRL] = (addr != cap_addr_q) || (wr != cap_wr_q);
        det[V_DATA] = cap_wr_q && (wdata != cap_wdata_q);
        if (rdy) begin
          done = 1'b1;
          ph_d = PH_IDLE;
        end else begin
          waitc = 1'b1;
          ph_d  = PH_WAIT;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q  <= '0;
      cap_wr_q    <= 1'b0;
      cap_wdata_q <= '0;
    end else if (cap_ld) begin
      cap_addr_q  <= addr;
      cap_wr_q    <= wr;
      cap_wdata_q <= wdata;
    end
  end
endmodule

// File: rtl/viol_log.sv
module viol_log
  import apb_rule_pkg::*;
#(
  parameter int N = NUM_VIOL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [N-1:0]      det,
  output logic [N-1:0]      flags,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] enc;
  logic [N-1:0]      flags_d;
  logic [CODE_W-1:0] code_d;
  logic              log_en;

  // lowest set position wins
  always_comb begin
    enc = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (det[i]) enc = CODE_W'(i + 1);
    end
  end

  always_comb begin
    log_en  = clr | (|det);
    flags_d = clr ? '0 : (flags | det);
    code_d  = clr ? '0 : ((code != '0) ? code : enc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      code  <= '0;
    end else if (log_en) begin
      flags <= flags_d;
      code  <= code_d;
    end
  end
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic         cnt_en;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_en = inc && (cnt != MAX);
    cnt_d  = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/apb_rule_watch.sv
module apb_rule_watch
  import apb_rule_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rst_n,
  input  logic                bus_sel,
  input  logic                bus_en,
  input  logic                bus_rdy,
  input  logic                bus_err,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_wr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic                viol_clr,
  output logic [NUM_VIOL-1:0] viol_flags,
  output logic [CODE_W-1:0]   viol_code,
  output logic [CNT_W-1:0]    xfer_cnt,
  output logic [CNT_W-1:0]    wait_cnt
);
  localparam int NCNT = 2;

  logic [NUM_VIOL-1:0] det;
  logic                done;
  logic                waitc;
  logic [NCNT-1:0]     cnt_inc;
  logic [CNT_W-1:0]    cnt_val [NCNT];

  apb_phase_track #(.AW(AW), .DW(DW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst_n (bus_rst_n),
    .sel       (bus_sel),
    .en        (bus_en),
    .rdy       (bus_rdy),
    .err       (bus_err),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .det       (det),
    .done      (done),
    .waitc     (waitc)
  );

  viol_log #(.N(NUM_VIOL)) u_log (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (viol_clr),
    .det   (det),
    .flags (viol_flags),
    .code  (viol_code)
  );

  assign cnt_inc = {waitc, done};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .cnt   (cnt_val[g])
    );
  end

  assign xfer_cnt = cnt_val[0];
  assign wait_cnt = cnt_val[1];
endmodule

// File: rtl/apb_rule_watch_chk.sv
module apb_rule_watch_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rst_n,
  input logic             bus_sel,
  input logic             bus_en,
  input logic             bus_rdy,
  input logic             bus_err,
  input logic             viol_clr,
  input logic [5:0]       viol_flags,
  input logic [2:0]       viol_code,
  input logic [CNT_W-1:0] xfer_cnt,
  input logic [CNT_W-1:0] wait_cnt
);
  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_clr |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

  a_r8_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_code != 3'd0 && !viol_clr) |=> (viol_code == $past(viol_code)));

  a_r8_code_with_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_code != 3'd0) == (viol_flags != 6'd0));

  a_r3_err_window: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_n && bus_err && !(bus_sel && bus_en && bus_rdy) && !viol_clr)
      |=> viol_flags[2]);

  a_r2_setup_twice: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_n && bus_sel && !bus_en && !viol_clr && $past(rst_n)
      && $past(bus_rst_n && bus_sel && !bus_en)) |=> viol_flags[1]);

  a_r6_sel_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rst_n && (bus_sel || bus_en) && !viol_clr) |=> viol_flags[5]);

  a_r9_xfer_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((xfer_cnt - $past(xfer_cnt)) <= CNT_W'(1)));

  a_r9_wait_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wait_cnt - $past(wait_cnt)) <= CNT_W'(1)));
endmodule

bind apb_rule_watch apb_rule_watch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rst_n  (bus_rst_n),
  .bus_sel    (bus_sel),
  .bus_en     (bus_en),
  .bus_rdy    (bus_rdy),
  .bus_err    (bus_err),
  .viol_clr   (viol_clr),
  .viol_flags (viol_flags),
  .viol_code  (viol_code),
  .xfer_cnt   (xfer_cnt),
  .wait_cnt   (wait_cnt)
);

// File: tb/sim_apb_rule_watch.sv
`timescale 1ns/1ps
module sim_apb_rule_watch;
  localparam int AW = 32, DW = 32, CNT_W = 8;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic clk = 1'b0;
  logic rst_n, bus_rst_n, sel, en, rdy, err, wr, clr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [5:0] flags;
  logic [2:0] code;
  logic [CNT_W-1:0] xc, wc;

  int n_chk = 0, n_bad = 0;

  // bench reference state
  int              m_st;
  logic [AW-1:0]   m_addr;
  logic            m_wr;
  logic [DW-1:0]   m_wd;
  logic [5:0]      m_flags;
  logic [2:0]      m_code;
  logic [CNT_W-1:0] m_xc, m_wc;

  always #2 clk = ~clk;

  apb_rule_watch #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .bus_sel(sel),
    .bus_en(en), .bus_rdy(rdy), .bus_err(err), .bus_addr(addr),
    .bus_wr(wr), .bus_wdata(wdata), .viol_clr(clr), .viol_flags(flags),
    .viol_code(code), .xfer_cnt(xc), .wait_cnt(wc));

  function automatic logic [2:0] first_code(input logic [5:0] d);
    for (int i = 0; i < 6; i++) if (d[i]) return 3'(i + 1);
    return 3'd0;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + CNT_W'(1);
  endfunction

  task automatic model_reset();
    m_st = 0; m_addr = '0; m_wr = 1'b0; m_wd = '0;
    m_flags = '0; m_code = '0; m_xc = '0; m_wc = '0;
  endtask

  // expected effect of the currently driven bus cycle
  task automatic model_step();
    logic [5:0] d;
    d = '0;
    if (!bus_rst_n) begin
      d[5] = sel | en; m_st = 0;
    end else begin
      d[2] = err && !(sel && en && rdy);
      if (!sel) begin d[0] = en; m_st = 0; end
      else if (!en) begin
        d[1] = (m_st == 1); m_st = 1; m_addr = addr; m_wr = wr; m_wd = wdata;
      end else if (m_st == 0) d[0] = 1'b1;
      else begin
        d[3] = (addr != m_addr) || (wr != m_wr);
        d[4] = m_wr && (wdata != m_wd);
        if (rdy) begin m_xc = sat_inc(m_xc); m_st = 0; end
        else begin m_wc = sat_inc(m_wc); m_st = 2; end
      end
    end
    if (clr) begin m_flags = '0; m_code = '0; end
    else begin
      if (m_code == 3'd0) m_code = first_code(d);
      m_flags = m_flags | d;
    end
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (flags !== m_flags || code !== m_code || xc !== m_xc || wc !== m_wc) begin
      n_bad++;
      $display("FAIL %s: got flags=%b code=%0d xfer=%0d wait=%0d, exp flags=%b code=%0d xfer=%0d wait=%0d",
               tag, flags, code, xc, wc, m_flags, m_code, m_xc, m_wc);
    end
  endtask

  // called at a falling edge with inputs set; checks right after the next rise (R11)
  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic bus(input logic s, input logic e, input logic r, input logic x);
    sel = s; en = e; rdy = r; err = x;
  endtask

  task automatic idle();
    bus(0, 0, 0, 0); clr = 1'b0; bus_rst_n = 1'b1;
  endtask

  task automatic do_clear(input string tag);
    idle(); clr = 1'b1; tick(tag); clr = 1'b0;
  endtask

  task automatic mon_reset();
    rst_n = 1'b0; idle(); model_reset();
    @(negedge clk);
    compare("R10");
    rst_n = 1'b1;
  endtask

  // inj: 0 extra setup, 1 err in setup, 2 addr change, 3 data change, 4 stray enable, other none
  task automatic xfer(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                      input int waits, input logic e_done, input int inj, input string tag);
    addr = a; wr = w; wdata = d;
    bus(1, 0, 0, inj == 1); tick(tag);
    if (inj == 0) tick(tag);
    if (inj == 2) addr = a ^ 32'h4;
    if (inj == 3) wdata = d ^ 32'h1;
    for (int k = 0; k < waits; k++) begin bus(1, 1, 0, 0); tick(tag); end
    bus(1, 1, 1, e_done); tick(tag);
    bus(0, inj == 4, 0, 0); tick(tag);
    bus(0, 0, 0, 0);
  endtask

  initial begin
    #(100000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung run, exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7301));
    rst_n = 1'b0; clr = 1'b0; bus_rst_n = 1'b1; wr = 1'b0; addr = '0; wdata = '0;
    bus(0, 0, 0, 0);
    model_reset();
    @(negedge clk); @(negedge clk);
    mon_reset();

    // R9: legal read with two waits, legal write with none
    xfer(32'h100, 1'b0, 32'h0, 2, 1'b0, 9, "R9");
    xfer(32'h104, 1'b1, 32'hA5A5, 0, 1'b0, 9, "R9");

    // R1: stray enable, then access from idle
    bus(0, 1, 0, 0); tick("R1"); do_clear("R8");
    bus(1, 1, 1, 0); tick("R1"); idle(); tick("R1"); do_clear("R8");

    // R2: doubled setup
    xfer(32'h20, 1'b0, 32'h0, 1, 1'b0, 0, "R2"); do_clear("R8");

    // R3: error in setup, error in wait, then legal error at completion
    xfer(32'h30, 1'b0, 32'h0, 1, 1'b0, 1, "R3"); do_clear("R8");
    addr = 32'h34; bus(1, 0, 0, 0); tick("R3");
    bus(1, 1, 0, 1); tick("R3"); bus(1, 1, 1, 0); tick("R3"); do_clear("R8");
    xfer(32'h38, 1'b1, 32'h9, 2, 1'b1, 9, "R3");

    // R4: address change in access, direction change at completion
    xfer(32'h40, 1'b0, 32'h0, 2, 1'b0, 2, "R4"); do_clear("R8");
    addr = 32'h44; wr = 1'b0; bus(1, 0, 0, 0); tick("R4");
    wr = 1'b1; bus(1, 1, 1, 0); tick("R4"); idle(); wr = 1'b0; do_clear("R8");

    // R5: data change on write flagged, on read ignored
    xfer(32'h50, 1'b1, 32'h1234, 1, 1'b0, 3, "R5"); do_clear("R8");
    xfer(32'h54, 1'b0, 32'h1234, 2, 1'b0, 3, "R5");

    // R6: select in bus reset; enable right after bus reset
    bus_rst_n = 1'b0; bus(1, 0, 0, 0); tick("R6"); do_clear("R8");
    addr = 32'h60; bus(1, 0, 0, 0); tick("R6");
    bus_rst_n = 1'b0; bus(0, 0, 0, 0); tick("R6");
    bus_rst_n = 1'b1; bus(1, 1, 1, 0); tick("R6"); idle(); tick("R6"); do_clear("R8");

    // R8: two breaches in one cycle, later breach keeps first code
    bus(0, 1, 0, 1); tick("R8");
    xfer(32'h70, 1'b0, 32'h0, 0, 1'b0, 0, "R8");
    // R7: flags persist through idle
    for (int k = 0; k < 4; k++) begin idle(); tick("R7"); end
    // R8: clear in same cycle as a breach
    clr = 1'b1; bus(0, 1, 0, 0); tick("R8"); clr = 1'b0; idle(); tick("R8");

    // R9: saturation of both counters
    for (int k = 0; k < 260; k++) begin
      addr = 32'(k); wr = 1'b0; bus(1, 0, 0, 0); tick("R9");
      bus(1, 1, 1, 0); tick("R9");
    end
    xfer(32'h80, 1'b0, 32'h0, 270, 1'b0, 9, "R9");

    // mid-run monitor reset, then random traffic
    mon_reset();
    for (int k = 0; k < 400; k++) begin
      int inj;
      inj = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 4)) : 9;
      xfer($urandom, 1'($urandom), $urandom, int'($urandom_range(0, 3)),
           1'($urandom_range(0, 3) == 0), inj, "R11");
      if ($urandom_range(0, 7) == 0) do_clear("R8");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule